// File: doc/BRIEF.md
# EPP 1.7 Parallel Port Cycle Engine

This block sits between an ISA-style host and a parallel-port peripheral. It turns host reads and writes of two enhanced-mode registers (an address register and a data register) into handshaked peripheral cycles. Each cycle uses the peripheral's wait line to pace the host through a ready output, so a slow peripheral stretches the host access instead of losing data.

When no enhanced cycle is running, the block behaves as a plain port. The host writes a control byte whose low bits drive three sideband outputs and whose direction bit sets whether the data bus is driven or floated. A data latch sets the byte on the bus. A cycle watchdog, counted in system clock cycles, aborts any enhanced cycle that stays open too long. The abort is recorded in a sticky status flag, and a host read of the status register clears it.

The host strobes and the register select are taken as synchronous to `clk`. The peripheral wait line is asynchronous and passes through a synchronizer chain. Every peripheral-side output and the host ready output come straight from flip-flops.

Top module: `epp_cycle_engine`

## Requirements
- R1: Out of reset and whenever no enhanced cycle runs: `per_strobe`, `per_autofd` and `per_init` equal control bits 0, 1 and 2. `per_data_oe` equals the inverse of control bit 5. `per_data_o` equals the port data latch. `per_write_n`, `per_dstb_n` and `per_astb_n` are high, and `host_rdy` is high. Control and data latch reset to 0.
- R2: Register select codes are 0 = port data latch, 1 = status, 2 = control, 3 = enhanced address, 4 = enhanced data. A read of 0 returns `per_data_i`, a read of 2 returns the control byte, and a read of 1 returns the time-out flag in bit 0 with zeros above it. A host access is taken on the falling edge of its strobe, and `host_rdata` is valid one clock later. Codes 5 to 7 read as zero, and writes to them (and to code 1) change nothing.
- R3: On a host write falling edge with select 3 or 4, one clock later `per_data_o` carries the host byte, `per_data_oe` and `per_write_n` are set for driving (1 and 0), and only the matching strobe is low: `per_astb_n` for select 3, `per_dstb_n` for select 4. The two strobes are never low together.
- R4: During an enhanced write, `host_rdy` follows the peripheral wait line after a two-flop synchronizer and one output register. It is low while `per_wait_n` is low and returns high within four clocks of its release.
- R5: When the host raises `host_wr_n`, the strobe and `per_write_n` return high one clock later. `per_data_o` keeps the written byte, which is also stored as the port data latch.
- R6: On a host read falling edge with select 3 or 4, one clock later `host_rdy` is low, `per_data_oe` is 0 and `per_write_n` is high. No strobe falls until the synchronized `per_wait_n` is seen low.
- R7: While a read strobe is low, seeing the synchronized `per_wait_n` high does three things at the next clock: it raises the strobe, loads `per_data_i` into `host_rdata`, and raises `host_rdy`.
- R8: An enhanced cycle still open `TMO_CYCLES` clocks after its start is aborted at exactly that clock. Both strobes go high, `per_write_n` goes high, `host_rdy` goes high and the time-out flag sets. The peripheral is ignored until the host starts a new access.
- R9: The time-out flag stays set until a host status read. That read returns 1 and clears the flag, so the next status read returns 0.
- R10: The watchdog count restarts with each enhanced cycle, so back-to-back cycles, each shorter than `TMO_CYCLES`, never time out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_sel | input | 3 | Register select (see R2) |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data |
| host_rdy | output | 1 | Host ready; low stretches the host access |
| per_data_o | output | DW | Peripheral data bus, driven value |
| per_data_oe | output | 1 | Peripheral data bus drive enable |
| per_data_i | input | DW | Peripheral data bus, sampled value |
| per_write_n | output | 1 | Cycle direction, low for a write |
| per_dstb_n | output | 1 | Data cycle strobe, active low |
| per_astb_n | output | 1 | Address cycle strobe, active low |
| per_wait_n | input | 1 | Peripheral wait/handshake, asynchronous |
| per_strobe | output | 1 | Sideband output from control bit 0 |
| per_autofd | output | 1 | Sideband output from control bit 1 |
| per_init | output | 1 | Sideband output from control bit 2 |

## Verification
The assertions check several properties on every cycle:
- the two strobes are never low together;
- a write always drives the bus and a read always floats it;
- a read strobe only falls after the synchronized wait line was seen low;
- an abort always releases the strobes and the ready output;
- the watchdog count never passes its limit;
- the time-out flag is sticky and clears on a status read.

Only the bench scenarios can show the rest. These are the exact clock of the abort at the boundary, the latched byte reaching the host, the ready output tracking wait across the synchronizer, and the time-out flag reading 1 once and then 0. They also cover the peripheral being ignored after an abort, the reserved select codes having no effect, and the idle pass-through across every control pattern.

// File: rtl/epp_pkg.sv
package epp_pkg;

   typedef enum logic [2:0] {
      SEL_PORT_DATA = 3'd0,
      SEL_STATUS    = 3'd1,
      SEL_CONTROL   = 3'd2,
      SEL_EPP_ADDR  = 3'd3,
      SEL_EPP_DATA  = 3'd4
   } host_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WR_STB = 2'd1,
      ST_RD_ARM = 2'd2,
      ST_RD_STB = 2'd3
   } cyc_state_e;

   localparam int CTL_STROBE_BIT = 0;
   localparam int CTL_AUTOFD_BIT = 1;
   localparam int CTL_INIT_BIT   = 2;
   localparam int CTL_DIR_BIT    = 5;
   localparam int STAT_TMO_BIT   = 0;
   localparam int SEL_W          = 3;

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_chk_stages
      $error("epp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   if (STAGES == 2) begin : g_two
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RESET_VAL}};
         else        chain <= {chain[0], d};
      end
   end else begin : g_deep
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RESET_VAL}};
         else        chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/epp_watchdog.sv
module epp_watchdog #(
   parameter int LIMIT = 1250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic active,
   output logic expire
);

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 2) begin : g_chk_limit
      $error("epp_watchdog: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (restart)                cnt <= '0;
      else if (active && cnt != LAST)  cnt <= cnt + 1'b1;
   end

   assign expire = active && !restart && (cnt == LAST);

   AST_WDOG_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST); // R8
   AST_WDOG_RESTART: assert property (@(posedge clk) disable iff (!rst_n) restart |=> !expire); // R10

endmodule

// File: rtl/epp_host_regs.sv
module epp_host_regs
   import epp_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_fire,
   input  logic              reg_rd_fire,
   input  logic [SEL_W-1:0]  sel,
   input  logic [DW-1:0]     wdata,
   input  logic [DW-1:0]     per_data_i,
   input  logic              epp_wr_fire,
   input  logic              tmo_set,
   output logic [DW-1:0]     ctl_q,
   output logic [DW-1:0]     data_q,
   output logic              tmo_q,
   output logic [DW-1:0]     rd_mux
);

   if (DW <= CTL_DIR_BIT) begin : g_chk_dw
      $error("epp_host_regs: DW too narrow for the control byte");
   end

   logic status_rd;
   assign status_rd = reg_rd_fire && (sel == SEL_STATUS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         data_q <= '0;
         tmo_q  <= 1'b0;
      end else begin
         if (reg_wr_fire && sel == SEL_CONTROL)   ctl_q  <= wdata;
         if (epp_wr_fire)                         data_q <= wdata;
         else if (reg_wr_fire && sel == SEL_PORT_DATA) data_q <= wdata;
         if (tmo_set)        tmo_q <= 1'b1;
         else if (status_rd) tmo_q <= 1'b0;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (sel)
         SEL_PORT_DATA: rd_mux = per_data_i;
         SEL_STATUS:    rd_mux[STAT_TMO_BIT] = tmo_q;
         SEL_CONTROL:   rd_mux = ctl_q;
         default:       rd_mux = '0;
      endcase
   end

   AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n) tmo_q && !status_rd |=> tmo_q); // R9
   AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) status_rd && !tmo_set |=> !tmo_q); // R9
   AST_TMO_SET: assert property (@(posedge clk) disable iff (!rst_n) tmo_set |=> tmo_q); // R8

endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
   import epp_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_rd_n,
   input  logic              host_wr_n,
   input  logic [SEL_W-1:0]  host_sel,
   input  logic [DW-1:0]     host_wdata,
   input  logic [DW-1:0]     per_data_i,
   input  logic              wait_s,
   input  logic [DW-1:0]     ctl_q,
   input  logic [DW-1:0]     data_q,
   input  logic [DW-1:0]     rd_mux,
   input  logic              expire,
   output logic              reg_wr_fire,
   output logic              reg_rd_fire,
   output logic              epp_wr_fire,
   output logic              tmo_set,
   output logic              wd_restart,
   output logic              wd_active,
   output logic [DW-1:0]     host_rdata,
   output logic              host_rdy,
   output logic [DW-1:0]     per_data_o,
   output logic              per_data_oe,
   output logic              per_write_n,
   output logic              per_dstb_n,
   output logic              per_astb_n
);

   cyc_state_e state, nxt;
   logic rd_prev, wr_prev, addr_q, addr_nxt;
   logic rd_fall, wr_fall, sel_is_epp;
   logic start_wr, start_rd, rd_done;

   assign rd_fall    = rd_prev && !host_rd_n;
   assign wr_fall    = wr_prev && !host_wr_n;
   assign sel_is_epp = (host_sel == SEL_EPP_ADDR) || (host_sel == SEL_EPP_DATA);

   always_comb begin
      nxt         = state;
      start_wr    = 1'b0;
      start_rd    = 1'b0;
      reg_wr_fire = 1'b0;
      reg_rd_fire = 1'b0;
      tmo_set     = 1'b0;
      rd_done     = 1'b0;
      case (state)
         ST_IDLE: begin
            if (wr_fall && sel_is_epp) begin
               start_wr = 1'b1;
               nxt      = ST_WR_STB;
            end else if (rd_fall && sel_is_epp) begin
               start_rd = 1'b1;
               nxt      = ST_RD_ARM;
            end else begin
               reg_wr_fire = wr_fall;
               reg_rd_fire = rd_fall;
            end
         end
         ST_WR_STB: begin
            if (expire) begin
               tmo_set = 1'b1;
               nxt     = ST_IDLE;
            end else if (host_wr_n) begin
               nxt = ST_IDLE;
            end
         end
         ST_RD_ARM: begin
            if (expire) begin
               tmo_set = 1'b1;
               nxt     = ST_IDLE;
            end else if (host_rd_n) begin
               nxt = ST_IDLE;
            end else if (!wait_s) begin
               nxt = ST_RD_STB;
            end
         end
         ST_RD_STB: begin
            if (expire) begin
               tmo_set = 1'b1;
               nxt     = ST_IDLE;
            end else if (host_rd_n) begin
               nxt = ST_IDLE;
            end else if (wait_s) begin
               rd_done = 1'b1;
               nxt     = ST_IDLE;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   assign epp_wr_fire = start_wr;
   assign wd_restart  = start_wr || start_rd;
   assign wd_active   = (state != ST_IDLE);
   assign addr_nxt    = wd_restart ? (host_sel == SEL_EPP_ADDR) : addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         rd_prev     <= 1'b1;
         wr_prev     <= 1'b1;
         addr_q      <= 1'b0;
         host_rdata  <= '0;
         host_rdy    <= 1'b1;
         per_data_o  <= '0;
         per_data_oe <= 1'b1;
         per_write_n <= 1'b1;
         per_dstb_n  <= 1'b1;
         per_astb_n  <= 1'b1;
      end else begin
         state   <= nxt;
         rd_prev <= host_rd_n;
         wr_prev <= host_wr_n;
         addr_q  <= addr_nxt;
         if (reg_rd_fire)  host_rdata <= rd_mux;
         else if (rd_done) host_rdata <= per_data_i;
         case (nxt)
            ST_WR_STB: begin
               per_data_o  <= start_wr ? host_wdata : data_q;
               per_data_oe <= 1'b1;
               per_write_n <= 1'b0;
               per_dstb_n  <= addr_nxt;
               per_astb_n  <= !addr_nxt;
               host_rdy    <= wait_s;
            end
            ST_RD_ARM: begin
               per_data_o  <= data_q;
               per_data_oe <= 1'b0;
               per_write_n <= 1'b1;
               per_dstb_n  <= 1'b1;
               per_astb_n  <= 1'b1;
               host_rdy    <= 1'b0;
            end
            ST_RD_STB: begin
               per_data_o  <= data_q;
               per_data_oe <= 1'b0;
               per_write_n <= 1'b1;
               per_dstb_n  <= addr_nxt;
               per_astb_n  <= !addr_nxt;
               host_rdy    <= 1'b0;
            end
            default: begin
               per_data_o  <= data_q;
               per_data_oe <= !ctl_q[CTL_DIR_BIT];
               per_write_n <= 1'b1;
               per_dstb_n  <= 1'b1;
               per_astb_n  <= 1'b1;
               host_rdy    <= 1'b1;
            end
         endcase
      end
   end

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) per_dstb_n || per_astb_n); // R3
   AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) !per_write_n |-> per_data_oe && !(per_dstb_n && per_astb_n)); // R3
   AST_READ_FLOATS: assert property (@(posedge clk) disable iff (!rst_n) !host_rdy && per_write_n |-> !per_data_oe); // R6
   AST_READ_STB_READY: assert property (@(posedge clk) disable iff (!rst_n) ($fell(per_dstb_n) || $fell(per_astb_n)) && per_write_n |-> !$past(wait_s)); // R6
   AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) tmo_set |=> host_rdy && per_dstb_n && per_astb_n && per_write_n); // R8

endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
   import epp_pkg::*;
#(
   parameter int DW          = 8,
   parameter int TMO_CYCLES  = 1250,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_rd_n,
   input  logic                host_wr_n,
   input  logic [SEL_W-1:0]    host_sel,
   input  logic [DW-1:0]       host_wdata,
   output logic [DW-1:0]       host_rdata,
   output logic                host_rdy,
   output logic [DW-1:0]       per_data_o,
   output logic                per_data_oe,
   input  logic [DW-1:0]       per_data_i,
   output logic                per_write_n,
   output logic                per_dstb_n,
   output logic                per_astb_n,
   input  logic                per_wait_n,
   output logic                per_strobe,
   output logic                per_autofd,
   output logic                per_init
);

   logic wait_s, expire;
   logic reg_wr_fire, reg_rd_fire, epp_wr_fire, tmo_set, wd_restart, wd_active;
   logic tmo_q;
   logic [DW-1:0] ctl_q, data_q, rd_mux;

   epp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_wait_sync (
      .clk(clk), .rst_n(rst_n), .d(per_wait_n), .q(wait_s)
   );

   epp_watchdog #(.LIMIT(TMO_CYCLES)) u_wdog (
      .clk(clk), .rst_n(rst_n), .restart(wd_restart), .active(wd_active), .expire(expire)
   );

   epp_host_regs #(.DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_fire(reg_wr_fire), .reg_rd_fire(reg_rd_fire),
      .sel(host_sel), .wdata(host_wdata), .per_data_i(per_data_i),
      .epp_wr_fire(epp_wr_fire), .tmo_set(tmo_set),
      .ctl_q(ctl_q), .data_q(data_q), .tmo_q(tmo_q), .rd_mux(rd_mux)
   );

   epp_cycle_fsm #(.DW(DW)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_sel(host_sel),
      .host_wdata(host_wdata), .per_data_i(per_data_i), .wait_s(wait_s),
      .ctl_q(ctl_q), .data_q(data_q), .rd_mux(rd_mux), .expire(expire),
      .reg_wr_fire(reg_wr_fire), .reg_rd_fire(reg_rd_fire), .epp_wr_fire(epp_wr_fire),
      .tmo_set(tmo_set), .wd_restart(wd_restart), .wd_active(wd_active),
      .host_rdata(host_rdata), .host_rdy(host_rdy),
      .per_data_o(per_data_o), .per_data_oe(per_data_oe), .per_write_n(per_write_n),
      .per_dstb_n(per_dstb_n), .per_astb_n(per_astb_n)
   );

   assign per_strobe = ctl_q[CTL_STROBE_BIT];
   assign per_autofd = ctl_q[CTL_AUTOFD_BIT];
   assign per_init   = ctl_q[CTL_INIT_BIT];

   AST_IDLE_TMO_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !wd_active |-> !tmo_set); // R8
   AST_TMO_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(tmo_q) |-> $past(wd_active)); // R8

endmodule

// File: tb/epp_cycle_engine_tb_top.sv
`timescale 1ns/1ps
module epp_cycle_engine_tb_top;

   localparam int DW  = 8;
   localparam int TMO = 24;

   logic clk = 1'b0;
   logic rst_n;
   logic host_rd_n, host_wr_n;
   logic [2:0] host_sel;
   logic [DW-1:0] host_wdata, host_rdata, per_data_o, per_data_i;
   logic host_rdy, per_data_oe, per_write_n, per_dstb_n, per_astb_n, per_wait_n;
   logic per_strobe, per_autofd, per_init;

   int n_cmp = 0;
   int n_mis = 0;

   always #4 clk = ~clk;

   epp_cycle_engine #(.DW(DW), .TMO_CYCLES(TMO), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_sel(host_sel),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdy(host_rdy),
      .per_data_o(per_data_o), .per_data_oe(per_data_oe), .per_data_i(per_data_i),
      .per_write_n(per_write_n), .per_dstb_n(per_dstb_n), .per_astb_n(per_astb_n),
      .per_wait_n(per_wait_n), .per_strobe(per_strobe), .per_autofd(per_autofd),
      .per_init(per_init)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_mis++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] s, input logic [DW-1:0] v);
      host_sel = s; host_wdata = v; host_wr_n = 1'b0;
      tick(1);
      host_wr_n = 1'b1;
      tick(2);
   endtask

   task automatic reg_read(input logic [2:0] s, output logic [DW-1:0] v);
      host_sel = s; host_rd_n = 1'b0;
      tick(1);
      v = host_rdata;
      host_rd_n = 1'b1;
      tick(1);
   endtask

   task automatic check_idle(input string tag);
      chk({tag, " dstb"}, 32'(per_dstb_n), 32'd1);
      chk({tag, " astb"}, 32'(per_astb_n), 32'd1);
      chk({tag, " write_n"}, 32'(per_write_n), 32'd1);
      chk({tag, " rdy"}, 32'(host_rdy), 32'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_mis++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end

   initial begin
      logic [DW-1:0] rv;
      rst_n = 1'b0; host_rd_n = 1'b1; host_wr_n = 1'b1; host_sel = 3'd0;
      host_wdata = '0; per_data_i = '0; per_wait_n = 1'b1;
      tick(3);
      rst_n = 1'b1;
      tick(2);

      // R1 reset state
      check_idle("R1 reset");
      chk("R1 reset oe", 32'(per_data_oe), 32'd1);
      chk("R1 reset data", 32'(per_data_o), 32'd0);
      reg_read(3'd1, rv);
      chk("R9 status after reset", 32'(rv), 32'd0);

      // R1/R2 control sweep
      for (int c = 0; c < 16; c++) begin
         logic [DW-1:0] cv;
         cv = DW'((c & 7) | ((c >> 3) << 5));
         reg_write(3'd2, cv);
         chk("R1 strobe", 32'(per_strobe), 32'(c & 1));
         chk("R1 autofd", 32'(per_autofd), 32'((c >> 1) & 1));
         chk("R1 init", 32'(per_init), 32'((c >> 2) & 1));
         chk("R1 oe", 32'(per_data_oe), 32'(((c >> 3) & 1) ^ 1));
         reg_read(3'd2, rv);
         chk("R2 control readback", 32'(rv), 32'(cv));
      end

      // R1/R2 port data latch and pin read
      reg_write(3'd2, 8'h00);
      for (int v = 0; v < 256; v += 17) begin
         reg_write(3'd0, DW'(v));
         chk("R1 data latch drive", 32'(per_data_o), 32'(v));
         per_data_i = DW'(255 - v);
         reg_read(3'd0, rv);
         chk("R2 pin read", 32'(rv), 32'(255 - v));
      end

      // R2 reserved codes and status write ignored
      reg_write(3'd2, 8'h05);
      reg_write(3'd0, 8'h3C);
      for (int s = 5; s < 8; s++) begin
         reg_write(3'(s), 8'hFF);
         reg_read(3'(s), rv);
         chk("R2 reserved reads zero", 32'(rv), 32'd0);
      end
      reg_write(3'd1, 8'hFF);
      reg_read(3'd2, rv);
      chk("R2 control untouched", 32'(rv), 32'h05);
      chk("R2 data untouched", 32'(per_data_o), 32'h3C);
      reg_read(3'd1, rv);
      chk("R2 status write ignored", 32'(rv), 32'd0);
      reg_write(3'd2, 8'h00);

      // R3/R5 enhanced write sweep
      per_wait_n = 1'b1;
      for (int s = 3; s < 5; s++) begin
         for (int v = 1; v < 256; v += 51) begin
            host_sel = 3'(s); host_wdata = DW'(v); host_wr_n = 1'b0;
            tick(1);
            chk("R3 write data", 32'(per_data_o), 32'(v));
            chk("R3 write oe", 32'(per_data_oe), 32'd1);
            chk("R3 write_n low", 32'(per_write_n), 32'd0);
            chk("R3 dstb", 32'(per_dstb_n), 32'(s != 4));
            chk("R3 astb", 32'(per_astb_n), 32'(s != 3));
            chk("R4 rdy ready", 32'(host_rdy), 32'd1);
            tick(2);
            chk("R3 strobe held", 32'(per_dstb_n & per_astb_n), 32'd0);
            host_wr_n = 1'b1;
            tick(1);
            check_idle("R5 end");
            tick(1);
            chk("R5 data kept", 32'(per_data_o), 32'(v));
         end
      end

      // R4 stall through the synchronizer
      per_wait_n = 1'b0;
      tick(3);
      host_sel = 3'd4; host_wdata = 8'hA5; host_wr_n = 1'b0;
      tick(1);
      chk("R4 rdy low", 32'(host_rdy), 32'd0);
      chk("R4 dstb low", 32'(per_dstb_n), 32'd0);
      tick(5);
      chk("R4 rdy still low", 32'(host_rdy), 32'd0);
      per_wait_n = 1'b1;
      tick(4);
      chk("R4 rdy released", 32'(host_rdy), 32'd1);
      chk("R4 strobe held", 32'(per_dstb_n), 32'd0);
      host_wr_n = 1'b1;
      tick(1);
      check_idle("R5 after stall");

      // R6/R7 enhanced read sweep
      reg_write(3'd2, 8'h20);
      for (int s = 3; s < 5; s++) begin
         for (int v = 7; v < 256; v += 62) begin
            per_wait_n = 1'b1;
            tick(3);
            host_sel = 3'(s); host_rd_n = 1'b0;
            tick(1);
            chk("R6 rdy low", 32'(host_rdy), 32'd0);
            chk("R6 float", 32'(per_data_oe), 32'd0);
            chk("R6 write_n high", 32'(per_write_n), 32'd1);
            tick(4);
            chk("R6 no strobe before ready", 32'(per_dstb_n & per_astb_n), 32'd1);
            per_wait_n = 1'b0;
            tick(4);
            chk("R6 dstb", 32'(per_dstb_n), 32'(s != 4));
            chk("R6 astb", 32'(per_astb_n), 32'(s != 3));
            per_data_i = DW'(v); per_wait_n = 1'b1;
            tick(4);
            chk("R7 strobe released", 32'(per_dstb_n & per_astb_n), 32'd1);
            chk("R7 rdy high", 32'(host_rdy), 32'd1);
            chk("R7 data", 32'(host_rdata), 32'(v));
            host_rd_n = 1'b1;
            tick(2);
         end
      end

      // R8 write time-out at the exact boundary
      reg_write(3'd2, 8'h00);
      per_wait_n = 1'b0;
      tick(3);
      host_sel = 3'd4; host_wdata = 8'h5A; host_wr_n = 1'b0;
      tick(1);
      tick(TMO - 1);
      chk("R8 not yet aborted rdy", 32'(host_rdy), 32'd0);
      chk("R8 not yet aborted dstb", 32'(per_dstb_n), 32'd0);
      tick(1);
      check_idle("R8 abort");
      per_wait_n = 1'b1;
      tick(4);
      per_wait_n = 1'b0;
      tick(4);
      check_idle("R8 ignore peripheral");
      host_wr_n = 1'b1;
      per_wait_n = 1'b1;
      tick(2);
      reg_read(3'd1, rv);
      chk("R9 status set", 32'(rv), 32'd1);
      reg_read(3'd1, rv);
      chk("R9 status cleared", 32'(rv), 32'd0);

      // R8 read time-out with peripheral never ready
      reg_write(3'd2, 8'h20);
      host_sel = 3'd3; host_rd_n = 1'b0;
      tick(1);
      tick(TMO - 1);
      chk("R8 read not yet aborted", 32'(host_rdy), 32'd0);
      tick(1);
      check_idle("R8 read abort");
      per_wait_n = 1'b0;
      tick(5);
      check_idle("R8 read ignore");
      host_rd_n = 1'b1; per_wait_n = 1'b1;
      tick(2);
      reg_read(3'd1, rv);
      chk("R9 status set read", 32'(rv), 32'd1);
      reg_read(3'd1, rv);
      chk("R9 status cleared read", 32'(rv), 32'd0);

      // R10 back-to-back cycles just under the limit
      reg_write(3'd2, 8'h00);
      per_wait_n = 1'b0;
      tick(3);
      for (int k = 0; k < 3; k++) begin
         host_sel = 3'd4; host_wdata = DW'(k); host_wr_n = 1'b0;
         tick(TMO - 3);
         chk("R10 still open", 32'(per_dstb_n), 32'd0);
         host_wr_n = 1'b1;
         tick(1);
      end
      per_wait_n = 1'b1;
      tick(2);
      reg_read(3'd1, rv);
      chk("R10 no time-out", 32'(rv), 32'd0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end

endmodule